// File: doc/BRIEF.md
# RAMDAC Palette Loader and Indirect Register Port

This block is the host-facing register front end of a RAMDAC. A host sees it through a window of four byte-wide addresses. A page-select input extends that window to eight direct registers. Through them the host sets a palette pointer and streams colour components into the palette. It also sets the pixel read mask, and reaches a 16-bit indirect register space through an index pair and a data port.

Palette loading is driven by a three-phase component state machine. Each completed triple is emitted as a one-cycle palette write strobe with the entry index and a 32-bit colour carrying alpha 255. The pointer then advances by one. In the indirect space the block keeps the pixel-format, clock-control, PLL-control and two frequency registers. From these it decodes the pixel depth and the PLL multiplier and dividers. It flags an unsupported pixel format, a bad PLL source and a non-default pixel mask.

The component states are PH_RED, PH_GREEN and PH_BLUE. A data write moves PH_RED to PH_GREEN and PH_GREEN to PH_BLUE. A data write in PH_BLUE commits the entry and returns to PH_RED. A palette-address write forces PH_RED from any state.

Top module: `ramdac_port`

## Requirements
- R1: After reset, pal_ptr is 0, the component phase is PH_RED, pix_mask is 8'hFF, mask_warn is 0, pll_en is 0, pix_depth is 0 and both error flags are 0.
- R2: A write with wr_byte low changes no register, pointer or phase.
- R3: The direct register number is {page_sel, wr_addr}, with this map: 0 palette address, 1 palette data, 2 pixel mask, 3 and 7 unused, 4 index low, 5 index high, 6 index data. Page 1 reaches registers 4 to 7.
- R4: A write to register 0 loads pal_ptr and returns the phase to PH_RED, discarding any partly collected entry.
- R5: The first, second and third writes to register 1 give red, green and blue. The cycle after the third write, pal_we pulses for one cycle with pal_wr_idx equal to the old pointer and pal_wr_rgba = {8'hFF, red, green, blue}. pal_ptr is then the old pointer plus 1.
- R6: pal_ptr wraps from 255 to 0.
- R7: A write to register 6 targets indirect address {index_high, index_low}. Only an exact 16-bit match selects an indirect register. The addresses are: 16'h000A pixel format, 16'h0002 clock control, 16'h0010 PLL control, 16'h0020 frequency F0, 16'h0021 frequency F1.
- R8: Writing 3 to pixel format sets pix_depth to 8 and clears fmt_bad. Any other value sets fmt_bad and leaves pix_depth unchanged.
- R9: A clock-control write with bit 0 set, while PLL control[1:0] is 1, does the following: pll_m = 8 >> F0[7:6], vco_div = F0[5:0] + 65, ref_div = F1[4:0] * pll_m, pll_en = 1, pll_src_bad = 0.
- R10: A clock-control write with bit 0 set, while PLL control[1:0] is not 1, sets pll_src_bad. It leaves pll_en and the divider outputs unchanged.
- R11: mask_warn is high whenever pix_mask is not 8'hFF.
- R12: A clock-control write with bit 0 clear makes pll_en 0 and keeps the divider outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Host write strobe |
| wr_byte | input | 1 | High for a single-byte access |
| wr_addr | input | 2 | Host byte address in the window |
| page_sel | input | 1 | Direct register page select |
| wr_data | input | 8 | Host write data |
| pal_we | output | 1 | Palette entry write pulse |
| pal_wr_idx | output | 8 | Index of the entry being written |
| pal_wr_rgba | output | 32 | {alpha, red, green, blue} of the entry |
| pal_ptr | output | 8 | Current palette pointer |
| pix_mask | output | 8 | Pixel read mask |
| mask_warn | output | 1 | Pixel mask is not 8'hFF |
| pix_depth | output | 6 | Decoded bits per pixel, 0 when unset |
| fmt_bad | output | 1 | Last pixel format was unsupported |
| pll_en | output | 1 | PLL enabled |
| pll_m | output | 4 | PLL multiplier |
| vco_div | output | 8 | VCO divide value |
| ref_div | output | 8 | Reference divide value |
| pll_src_bad | output | 1 | PLL source field invalid at enable |

## Verification
Every result is registered once, so it appears in the first cycle after the clock edge that takes the write. mask_warn is the exception: it is combinational from the mask register and so shows in the same cycle as pix_mask. The bench applies each write on a falling edge and holds it across one rising edge. It then samples on the next falling edge, which is inside the single cycle in which pal_we is high. For the ignored-write cases, the pointer, mask and phase are read back after the stimulus. The phase is read back by completing a triple and checking which components land in which field.

// File: rtl/ramdac_pkg.sv
package ramdac_pkg;
    typedef enum logic [1:0] {PH_RED, PH_GREEN, PH_BLUE} phase_t;

    localparam logic [2:0] DR_PAL_ADDR = 3'd0;
    localparam logic [2:0] DR_PAL_DATA = 3'd1;
    localparam logic [2:0] DR_PIX_MASK = 3'd2;
    localparam logic [2:0] DR_IDX_LO   = 3'd4;
    localparam logic [2:0] DR_IDX_HI   = 3'd5;
    localparam logic [2:0] DR_IDX_DATA = 3'd6;

    typedef struct packed {
        logic pal_addr;
        logic pal_data;
        logic pix_mask;
        logic idx_lo;
        logic idx_hi;
        logic idx_data;
    } dir_wr_t;
endpackage

// File: rtl/ramdac_decode.sv
module ramdac_decode
    import ramdac_pkg::*;
(
    input  logic       wr_en,
    input  logic       wr_byte,
    input  logic       page_sel,
    input  logic [1:0] wr_addr,
    output dir_wr_t    strobes
);
    logic [2:0] reg_num;
    logic       take;

    always_comb begin
        reg_num = {page_sel, wr_addr};
        take    = wr_en && wr_byte;
        strobes = '0;
        if (take) begin
            unique case (reg_num)
                DR_PAL_ADDR: strobes.pal_addr = 1'b1;
                DR_PAL_DATA: strobes.pal_data = 1'b1;
                DR_PIX_MASK: strobes.pix_mask = 1'b1;
                DR_IDX_LO:   strobes.idx_lo   = 1'b1;
                DR_IDX_HI:   strobes.idx_hi   = 1'b1;
                DR_IDX_DATA: strobes.idx_data = 1'b1;
                default:     strobes          = '0;
            endcase
        end
    end
endmodule

// File: rtl/ramdac_pal_seq.sv
module ramdac_pal_seq
    import ramdac_pkg::*;
#(
    parameter int CW = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            ld_addr,
    input  logic            ld_data,
    input  logic [CW-1:0]   din,
    output logic            pal_we,
    output logic [CW-1:0]   pal_wr_idx,
    output logic [4*CW-1:0] pal_wr_rgba,
    output logic [CW-1:0]   pal_ptr
);
    localparam logic [CW-1:0] ALPHA = {CW{1'b1}};

    phase_t        state, state_nx;
    logic [CW-1:0] red_q, green_q;

    always_comb begin
        state_nx = state;
        if (ld_addr) begin
            state_nx = PH_RED;
        end else if (ld_data) begin
            unique case (state)
                PH_RED:   state_nx = PH_GREEN;
                PH_GREEN: state_nx = PH_BLUE;
                PH_BLUE:  state_nx = PH_RED;
                default:  state_nx = PH_RED;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= PH_RED;
        else        state <= state_nx;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            red_q       <= '0;
            green_q     <= '0;
            pal_we      <= 1'b0;
            pal_wr_idx  <= '0;
            pal_wr_rgba <= '0;
            pal_ptr     <= '0;
        end else begin
            pal_we <= 1'b0;
            if (ld_addr) begin
                pal_ptr <= din;
            end else if (ld_data) begin
                unique case (state)
                    PH_RED:   red_q   <= din;
                    PH_GREEN: green_q <= din;
                    PH_BLUE: begin
                        pal_we      <= 1'b1;
                        pal_wr_idx  <= pal_ptr;
                        pal_wr_rgba <= {ALPHA, red_q, green_q, din};
                        pal_ptr     <= pal_ptr + 1'b1;
                    end
                    default: red_q <= red_q;
                endcase
            end
        end
    end
endmodule

// File: rtl/ramdac_ind_regs.sv
module ramdac_ind_regs #(
    parameter int          DW          = 8,
    parameter int          IW          = 16,
    parameter logic [15:0] A_PIX_FMT   = 16'h000A,
    parameter logic [15:0] A_CLK_CTL   = 16'h0002,
    parameter logic [15:0] A_PLL_CTL   = 16'h0010,
    parameter logic [15:0] A_FREQ0     = 16'h0020,
    parameter logic [15:0] A_FREQ1     = 16'h0021,
    parameter logic [DW-1:0] FMT_8BPP  = 8'd3,
    parameter int          DEPTH_W     = 6,
    parameter int          VCO_BIAS    = 65
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               ld_lo,
    input  logic               ld_hi,
    input  logic               ld_data,
    input  logic [DW-1:0]      din,
    output logic [DEPTH_W-1:0] pix_depth,
    output logic               fmt_bad,
    output logic               pll_en,
    output logic [3:0]         pll_m,
    output logic [7:0]         vco_div,
    output logic [7:0]         ref_div,
    output logic               pll_src_bad
);
    localparam int HW = IW - DW;

    logic [DW-1:0] idx_lo, idx_hi;
    logic [DW-1:0] pll_ctl_q, f0_q, f1_q;
    logic [IW-1:0] ind_addr;
    logic [3:0]    m_calc;
    logic [7:0]    vco_calc;
    logic [7:0]    ref_calc;

    always_comb begin
        ind_addr = {idx_hi[HW-1:0], idx_lo};
        m_calc   = 4'd8 >> f0_q[7:6];
        vco_calc = {2'b00, f0_q[5:0]} + 8'(VCO_BIAS);
        ref_calc = 8'({3'b000, f1_q[4:0]} * {4'b0000, m_calc});
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx_lo      <= '0;
            idx_hi      <= '0;
            pll_ctl_q   <= '0;
            f0_q        <= '0;
            f1_q        <= '0;
            pix_depth   <= '0;
            fmt_bad     <= 1'b0;
            pll_en      <= 1'b0;
            pll_m       <= '0;
            vco_div     <= '0;
            ref_div     <= '0;
            pll_src_bad <= 1'b0;
        end else begin
            if (ld_lo) idx_lo <= din;
            if (ld_hi) idx_hi <= din;
            if (ld_data) begin
                if (ind_addr == A_PLL_CTL) pll_ctl_q <= din;
                if (ind_addr == A_FREQ0)   f0_q      <= din;
                if (ind_addr == A_FREQ1)   f1_q      <= din;
                if (ind_addr == A_PIX_FMT) begin
                    if (din == FMT_8BPP) begin
                        pix_depth <= DEPTH_W'(8);
                        fmt_bad   <= 1'b0;
                    end else begin
                        fmt_bad   <= 1'b1;
                    end
                end
                if (ind_addr == A_CLK_CTL) begin
                    if (!din[0]) begin
                        pll_en <= 1'b0;
                    end else if (pll_ctl_q[1:0] == 2'b01) begin
                        pll_en      <= 1'b1;
                        pll_src_bad <= 1'b0;
                        pll_m       <= m_calc;
                        vco_div     <= vco_calc;
                        ref_div     <= ref_calc;
                    end else begin
                        pll_src_bad <= 1'b1;
                    end
                end
            end
        end
    end
endmodule

// File: rtl/ramdac_port.sv
module ramdac_port
    import ramdac_pkg::*;
#(
    parameter int CW = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en,
    input  logic            wr_byte,
    input  logic [1:0]      wr_addr,
    input  logic            page_sel,
    input  logic [CW-1:0]   wr_data,
    output logic            pal_we,
    output logic [CW-1:0]   pal_wr_idx,
    output logic [4*CW-1:0] pal_wr_rgba,
    output logic [CW-1:0]   pal_ptr,
    output logic [CW-1:0]   pix_mask,
    output logic            mask_warn,
    output logic [5:0]      pix_depth,
    output logic            fmt_bad,
    output logic            pll_en,
    output logic [3:0]      pll_m,
    output logic [7:0]      vco_div,
    output logic [7:0]      ref_div,
    output logic            pll_src_bad
);
    dir_wr_t strobes;

    ramdac_decode u_dec (
        .wr_en    (wr_en),
        .wr_byte  (wr_byte),
        .page_sel (page_sel),
        .wr_addr  (wr_addr),
        .strobes  (strobes)
    );

    ramdac_pal_seq #(.CW(CW)) u_pal (
        .clk         (clk),
        .rst_n       (rst_n),
        .ld_addr     (strobes.pal_addr),
        .ld_data     (strobes.pal_data),
        .din         (wr_data),
        .pal_we      (pal_we),
        .pal_wr_idx  (pal_wr_idx),
        .pal_wr_rgba (pal_wr_rgba),
        .pal_ptr     (pal_ptr)
    );

    ramdac_ind_regs #(.DW(CW)) u_ind (
        .clk         (clk),
        .rst_n       (rst_n),
        .ld_lo       (strobes.idx_lo),
        .ld_hi       (strobes.idx_hi),
        .ld_data     (strobes.idx_data),
        .din         (wr_data),
        .pix_depth   (pix_depth),
        .fmt_bad     (fmt_bad),
        .pll_en      (pll_en),
        .pll_m       (pll_m),
        .vco_div     (vco_div),
        .ref_div     (ref_div),
        .pll_src_bad (pll_src_bad)
    );

    always_ff @(posedge clk) begin
        if (!rst_n)                pix_mask <= {CW{1'b1}};
        else if (strobes.pix_mask) pix_mask <= wr_data;
    end

    assign mask_warn = (pix_mask != {CW{1'b1}});
endmodule

// File: rtl/ramdac_port_chk.sv
module ramdac_port_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        wr_en,
    input logic        wr_byte,
    input logic        pal_we,
    input logic [7:0]  pal_wr_idx,
    input logic [31:0] pal_wr_rgba,
    input logic [7:0]  pal_ptr,
    input logic [7:0]  pix_mask,
    input logic [5:0]  pix_depth,
    input logic        pll_en,
    input logic [7:0]  vco_div
);
    a_r5_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        pal_we |=> !pal_we);

    a_r5_ptr_advance: assert property (@(posedge clk) disable iff (!rst_n)
        pal_we |-> (pal_ptr == pal_wr_idx + 8'd1));

    a_r5_alpha_full: assert property (@(posedge clk) disable iff (!rst_n)
        pal_we |-> (pal_wr_rgba[31:24] == 8'hFF));

    a_r2_no_write_stable: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && wr_byte) |=> ($stable(pal_ptr) && $stable(pix_mask) && !pal_we));

    a_r8_depth_legal: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_depth == 6'd0) || (pix_depth == 6'd8));

    a_r9_vco_bias: assert property (@(posedge clk) disable iff (!rst_n)
        pll_en |-> (vco_div >= 8'd65));
endmodule

bind ramdac_port ramdac_port_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_en       (wr_en),
    .wr_byte     (wr_byte),
    .pal_we      (pal_we),
    .pal_wr_idx  (pal_wr_idx),
    .pal_wr_rgba (pal_wr_rgba),
    .pal_ptr     (pal_ptr),
    .pix_mask    (pix_mask),
    .pix_depth   (pix_depth),
    .pll_en      (pll_en),
    .vco_div     (vco_div)
);

// File: tb/tb_ramdac_port.sv
module tb_ramdac_port;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic        wr_byte = 1'b0;
    logic [1:0]  wr_addr = '0;
    logic        page_sel = 1'b0;
    logic [7:0]  wr_data = '0;
    logic        pal_we;
    logic [7:0]  pal_wr_idx;
    logic [31:0] pal_wr_rgba;
    logic [7:0]  pal_ptr;
    logic [7:0]  pix_mask;
    logic        mask_warn;
    logic [5:0]  pix_depth;
    logic        fmt_bad;
    logic        pll_en;
    logic [3:0]  pll_m;
    logic [7:0]  vco_div;
    logic [7:0]  ref_div;
    logic        pll_src_bad;

    int total = 0;
    int bad = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    ramdac_port dut (.*);

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // one write held across one rising edge; returns at the following falling edge
    task automatic wr(input logic [2:0] reg_num, input logic [7:0] d, input logic byte_acc = 1'b1);
        @(negedge clk);
        wr_en = 1'b1; wr_byte = byte_acc;
        page_sel = reg_num[2]; wr_addr = reg_num[1:0]; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0; wr_byte = 1'b0;
    endtask

    task automatic ind_wr(input logic [15:0] a, input logic [7:0] d);
        wr(3'd4, a[7:0]);
        wr(3'd5, a[15:8]);
        wr(3'd6, d);
    endtask

    task automatic t_reset;
        check("R1 ptr", pal_ptr, 0);
        check("R1 mask", pix_mask, 8'hFF);
        check("R1 warn", mask_warn, 0);
        check("R1 pll_en", pll_en, 0);
        check("R1 depth", pix_depth, 0);
        check("R1 flags", {fmt_bad, pll_src_bad}, 0);
        wr(3'd1, 8'h11); wr(3'd1, 8'h22); wr(3'd1, 8'h33);
        check("R1 phase red at reset", pal_wr_rgba, 32'hFF112233);
    endtask

    task automatic t_triple;
        wr(3'd0, 8'h40);
        check("R4 ptr load", pal_ptr, 8'h40);
        wr(3'd1, 8'hA1); check("R5 no early strobe", pal_we, 0);
        wr(3'd1, 8'hB2); check("R5 no early strobe", pal_we, 0);
        wr(3'd1, 8'hC3);
        check("R5 strobe", pal_we, 1);
        check("R5 idx", pal_wr_idx, 8'h40);
        check("R5 rgba", pal_wr_rgba, 32'hFFA1B2C3);
        check("R5 ptr inc", pal_ptr, 8'h41);
        @(negedge clk);
        check("R5 pulse ends", pal_we, 0);
    endtask

    task automatic t_addr_resets_phase;
        wr(3'd1, 8'h01); wr(3'd1, 8'h02);
        wr(3'd0, 8'h10);
        wr(3'd1, 8'h0A); wr(3'd1, 8'h0B); wr(3'd1, 8'h0C);
        check("R4 phase reset", pal_wr_rgba, 32'hFF0A0B0C);
        check("R4 idx", pal_wr_idx, 8'h10);
    endtask

    task automatic t_wrap;
        wr(3'd0, 8'hFF);
        wr(3'd1, 8'h5); wr(3'd1, 8'h6); wr(3'd1, 8'h7);
        check("R6 idx 255", pal_wr_idx, 8'hFF);
        check("R6 wrap", pal_ptr, 8'h00);
    endtask

    task automatic t_wide_ignored;
        wr(3'd0, 8'h20);
        wr(3'd0, 8'h77, 1'b0);
        wr(3'd2, 8'h00, 1'b0);
        check("R2 ptr kept", pal_ptr, 8'h20);
        check("R2 mask kept", pix_mask, 8'hFF);
        wr(3'd1, 8'h99, 1'b0);
        wr(3'd1, 8'h1); wr(3'd1, 8'h2); wr(3'd1, 8'h3);
        check("R2 phase kept", pal_wr_rgba, 32'hFF010203);
    endtask

    task automatic t_page;
        wr(3'd0, 8'h30);
        wr(3'd4, 8'h55);
        check("R3 page1 not palette", pal_ptr, 8'h30);
        wr(3'd3, 8'h00);
        wr(3'd7, 8'h00);
        check("R3 unused regs", {pal_ptr, pix_mask}, {8'h30, 8'hFF});
    endtask

    task automatic t_mask;
        wr(3'd2, 8'h0F);
        check("R11 mask", pix_mask, 8'h0F);
        check("R11 warn", mask_warn, 1);
        wr(3'd2, 8'hFF);
        check("R11 warn clear", mask_warn, 0);
    endtask

    task automatic t_format;
        ind_wr(16'h010A, 8'd3);
        check("R7 exact match", {pix_depth, fmt_bad}, {6'd0, 1'b0});
        ind_wr(16'h000A, 8'd3);
        check("R8 depth", pix_depth, 8);
        ind_wr(16'h000A, 8'd4);
        check("R8 bad flag", fmt_bad, 1);
        check("R8 depth kept", pix_depth, 8);
        ind_wr(16'h000A, 8'd3);
        check("R8 flag clear", fmt_bad, 0);
    endtask

    task automatic t_pll;
        ind_wr(16'h0020, 8'h85);
        ind_wr(16'h0021, 8'h0C);
        ind_wr(16'h0010, 8'h00);
        ind_wr(16'h0002, 8'h01);
        check("R10 src bad", pll_src_bad, 1);
        check("R10 no enable", {pll_en, pll_m, vco_div, ref_div}, 0);
        ind_wr(16'h0010, 8'h01);
        ind_wr(16'h0002, 8'h01);
        check("R9 enable", {pll_en, pll_src_bad}, 2'b10);
        check("R9 m", pll_m, 2);
        check("R9 vco", vco_div, 70);
        check("R9 ref", ref_div, 24);
        ind_wr(16'h0020, 8'h3F);
        ind_wr(16'h0021, 8'h1F);
        ind_wr(16'h0002, 8'h01);
        check("R9 m=8", pll_m, 8);
        check("R9 vco max", vco_div, 128);
        check("R9 ref max", ref_div, 248);
        ind_wr(16'h0002, 8'h00);
        check("R12 disable", pll_en, 0);
        check("R12 hold", {pll_m, vco_div, ref_div}, {4'd8, 8'd128, 8'd248});
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset;
        t_triple;
        t_addr_resets_phase;
        t_wrap;
        t_wide_ignored;
        t_page;
        t_mask;
        t_format;
        t_pll;
        done = 1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                total++; bad++;
                $display("FAIL watchdog actual=running expected=done");
            end
        join_any
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule